// File: doc/BRIEF.md
# Interrupt Entry Micro-Sequencer

This block is the control sequencer of a small processor. It looks for interrupts only at instruction boundaries. Each instruction runs as a one-cycle fetch followed by an execute phase. The execute phase is modelled by an external completion strobe, which carries two attribute bits: "return from handler" and "enable interrupts".

When an execute phase finishes with interrupts enabled and a request pending, the sequencer does not go back to fetch. It enters a two-cycle interrupt path instead:
- In the first cycle it saves the program counter on an internal LIFO.
- In the second cycle it raises a one-cycle acknowledge and latches a 4-bit vector from the data bus.
- It then loads the program counter with the handler address: four ones, then the vector, then four zeros.

A return instruction pops the saved address and re-enables interrupts.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset the outputs are as follows: `pc` is 0, `fetch` is high, `ie_flag` is 1, and `ip_flag`, `iack`, `in_entry` and `stack_err` are 0.
- R2: The interrupt path is entered only on the edge where `exec_done` is high, `op_ret` is low, and the registered `ie_flag` and `ip_flag` are both 1. Otherwise the next state after execute is fetch, and `fetch` is high in the following cycle.
- R3: The first entry cycle saves the `pc` value held at that moment, which is the address of the next instruction, before `pc` changes.
- R4: `iack` is high for exactly one cycle, in the second entry cycle. `ie_flag` is 0 from that cycle on.
- R5: At the end of the acknowledge cycle `pc` becomes {4'b1111, `vec_in`, 4'b0000}, using `vec_in` as sampled in that cycle. `fetch` follows.
- R6: When `exec_done` and `op_ret` are both high, `pc` is loaded with the most recently saved address, `ie_flag` is set to 1, and fetch resumes there.
- R7: `ip_flag` is set at any edge where `irq` is high. It is cleared at the acknowledge edge, and the clear wins over a simultaneous `irq`.
- R8: `exec_done` with `op_ei` high sets `ie_flag` to 1. The boundary decision on that same edge uses the old `ie_flag`.
- R9: The save stack holds 8 addresses in LIFO order. A save when the stack is full sets `stack_err`, stores nothing and leaves the stack unchanged, and the entry still completes.
- R10: A return with an empty stack sets `stack_err`, leaves `pc` unchanged and still sets `ie_flag`.
- R11: `stack_err` stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq | input | 1 | Active-high interrupt request |
| exec_done | input | 1 | Execute phase of current instruction finishes this cycle |
| op_ret | input | 1 | Finishing instruction is a return from handler |
| op_ei | input | 1 | Finishing instruction enables interrupts |
| vec_in | input | 4 | Interrupt vector from the data bus |
| pc | output | 12 | Program counter |
| fetch | output | 1 | Sequencer is in the fetch cycle |
| in_entry | output | 1 | Sequencer is in one of the two entry cycles |
| iack | output | 1 | Interrupt acknowledge |
| ie_flag | output | 1 | Interrupt enable |
| ip_flag | output | 1 | Interrupt pending |
| stack_err | output | 1 | Sticky stack overflow/underflow flag |

## Verification
The bench sweeps all sixteen vector values through a full entry and return. Each handler address and each restored address is predicted from the arithmetic.

Requests are timed in several ways:
- A request raised mid-execute, held while `exec_done` stays low, shows the boundary-only sampling.
- A request arriving on the same edge as completion separates the registered flag from the raw input.
- A request held through the acknowledge separates clear priority from set priority.

Nested entries driven to nine levels tell LIFO order apart from overflow handling. A return on an empty stack isolates underflow.

// File: rtl/irq_entry_seq.sv
module irq_entry_seq #(
  parameter int   VEC_W   = 4,
  parameter int   DEPTH   = 8,
  parameter logic IE_INIT = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               irq,
  input  logic               exec_done,
  input  logic               op_ret,
  input  logic               op_ei,
  input  logic [VEC_W-1:0]   vec_in,
  output logic [VEC_W+7:0]   pc,
  output logic               fetch,
  output logic               in_entry,
  output logic               iack,
  output logic               ie_flag,
  output logic               ip_flag,
  output logic               stack_err
);
  localparam int PC_W = VEC_W + 8;
  localparam int AW   = $clog2(DEPTH);
  localparam int SP_W = $clog2(DEPTH + 1);

  typedef enum logic [1:0] {S_FETCH, S_EXEC, S_SAVE, S_ACK} st_t;

  st_t               state;
  logic [SP_W-1:0]   sp;
  logic [PC_W-1:0]   stk [DEPTH];

  wire full  = (sp == SP_W'(DEPTH));
  wire empty = (sp == '0);
  wire [AW-1:0] push_idx = AW'(sp);
  wire [AW-1:0] top_idx  = AW'(sp - 1'b1);
  wire [PC_W-1:0] handler = {4'b1111, vec_in, 4'b0000};

  assign fetch    = (state == S_FETCH);
  assign in_entry = (state == S_SAVE) || (state == S_ACK);
  assign iack     = (state == S_ACK);

  always_ff @(posedge clk) begin
    if (state == S_SAVE && !full) stk[push_idx] <= pc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_FETCH;
      pc        <= '0;
      sp        <= '0;
      ie_flag   <= IE_INIT;
      ip_flag   <= 1'b0;
      stack_err <= 1'b0;
    end else begin
      if (state == S_ACK)  ip_flag <= 1'b0;
      else if (irq)        ip_flag <= 1'b1;

      case (state)
        S_FETCH: begin
          pc    <= pc + 1'b1;
          state <= S_EXEC;
        end
        S_EXEC: if (exec_done) begin
          if (op_ret) begin
            ie_flag <= 1'b1;
            state   <= S_FETCH;
            if (empty) stack_err <= 1'b1;
            else begin
              pc <= stk[top_idx];
              sp <= sp - 1'b1;
            end
          end else begin
            if (op_ei) ie_flag <= 1'b1;
            state <= (ie_flag && ip_flag) ? S_SAVE : S_FETCH;
          end
        end
        S_SAVE: begin
          ie_flag <= 1'b0;
          state   <= S_ACK;
          if (full) stack_err <= 1'b1;
          else      sp <= sp + 1'b1;
        end
        default: begin
          pc    <= handler;
          state <= S_FETCH;
        end
      endcase
    end
  end
endmodule

module irq_entry_seq_chk #(
  parameter int VEC_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             exec_done,
  input logic             op_ret,
  input logic [VEC_W-1:0] vec_in,
  input logic [VEC_W+7:0] pc,
  input logic             in_entry,
  input logic             iack,
  input logic             ie_flag,
  input logic             ip_flag,
  input logic             stack_err
);
  a_r2_entry_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_entry) |-> $past(exec_done && !op_ret && ie_flag && ip_flag));

  a_r4_iack_single: assert property (@(posedge clk) disable iff (!rst_n)
    iack |=> !iack);

  a_r4_ie_low_in_ack: assert property (@(posedge clk) disable iff (!rst_n)
    iack |-> !ie_flag);

  a_r5_handler_addr: assert property (@(posedge clk) disable iff (!rst_n)
    iack |=> pc == {4'b1111, $past(vec_in), 4'b0000});

  a_r7_ip_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    iack |=> !ip_flag);

  a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    stack_err |=> stack_err);
endmodule

bind irq_entry_seq irq_entry_seq_chk #(.VEC_W(VEC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .exec_done(exec_done), .op_ret(op_ret),
  .vec_in(vec_in), .pc(pc), .in_entry(in_entry), .iack(iack),
  .ie_flag(ie_flag), .ip_flag(ip_flag), .stack_err(stack_err)
);

// File: tb/irq_entry_seq_test.sv
`timescale 1ns/1ps
module irq_entry_seq_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic irq = 0, exec_done = 0, op_ret = 0, op_ei = 0;
  logic [3:0] vec_in = '0;
  logic [11:0] pc;
  logic fetch, in_entry, iack, ie_flag, ip_flag, stack_err;

  int checks = 0, failures = 0;
  bit finished = 0;
  logic [11:0] exp_pc;
  logic [11:0] mstk [8];
  int msp = 0;

  always #2.5 clk = ~clk;

  irq_entry_seq uut (
    .clk(clk), .rst_n(rst_n), .irq(irq), .exec_done(exec_done),
    .op_ret(op_ret), .op_ei(op_ei), .vec_in(vec_in), .pc(pc),
    .fetch(fetch), .in_entry(in_entry), .iack(iack), .ie_flag(ie_flag),
    .ip_flag(ip_flag), .stack_err(stack_err)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic do_reset();
    rst_n = 0; irq = 0; exec_done = 0; op_ret = 0; op_ei = 0;
    repeat (2) cyc();
    rst_n = 1;
    exp_pc = 0; msp = 0;
  endtask

  task automatic fetch_cycle(bit pulse_irq);
    irq = pulse_irq;
    cyc();
    irq = 0;
    exp_pc = exp_pc + 1;
  endtask

  task automatic finish_exec(bit ret, bit ei, bit irq_same);
    exec_done = 1; op_ret = ret; op_ei = ei; irq = irq_same;
    cyc();
    exec_done = 0; op_ret = 0; op_ei = 0; irq = 0;
  endtask

  task automatic enter(logic [3:0] v, bit hold_irq);
    check("R3 save cycle iack low", iack, 0);
    if (msp < 8) mstk[msp] = exp_pc;
    msp++;
    cyc();
    check("R4 iack high", iack, 1);
    check("R4 ie cleared", ie_flag, 0);
    vec_in = v; irq = hold_irq;
    cyc();
    irq = 0;
    exp_pc = {4'hF, v, 4'h0};
    check("R5 handler pc", pc, exp_pc);
    check("R4 iack dropped", iack, 0);
    check("R7 ip cleared at ack", ip_flag, 0);
    check("R5 fetch after entry", fetch, 1);
  endtask

  task automatic do_return(string tag);
    fetch_cycle(0);
    finish_exec(1, 0, 0);
    msp--;
    exp_pc = mstk[msp];
    check(tag, pc, exp_pc);
    check("R6 ie restored", ie_flag, 1);
    check("R6 fetch resumes", fetch, 1);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    do_reset();
    check("R1 pc", pc, 0);
    check("R1 fetch", fetch, 1);
    check("R1 ie", ie_flag, 1);
    check("R1 ip", ip_flag, 0);
    check("R1 iack", iack, 0);
    check("R1 entry", in_entry, 0);
    check("R1 err", stack_err, 0);

    fetch_cycle(0);
    cyc(); cyc();
    finish_exec(0, 0, 0);
    check("R2 plain fetch", fetch, 1);
    check("R2 pc", pc, exp_pc);

    fetch_cycle(0);
    finish_exec(1, 0, 0);
    check("R10 underflow err", stack_err, 1);
    check("R10 pc kept", pc, exp_pc);
    check("R10 ie set", ie_flag, 1);
    fetch_cycle(0);
    finish_exec(0, 0, 0);
    check("R11 err sticky", stack_err, 1);

    do_reset();
    for (int v = 0; v < 16; v++) begin
      fetch_cycle(1);
      check("R7 ip set", ip_flag, 1);
      cyc();
      check("R2 no entry mid-instruction", in_entry, 0);
      cyc();
      check("R2 still pending", ip_flag, 1);
      finish_exec(0, 0, 0);
      check("R2 entry at boundary", in_entry, 1);
      enter(4'(v), v == 5);
      do_return("R3 R6 return address");
      fetch_cycle(0);
      finish_exec(0, 0, 0);
    end

    fetch_cycle(1);
    finish_exec(0, 0, 0);
    check("R2 entry", in_entry, 1);
    enter(4'h9, 0);
    fetch_cycle(1);
    finish_exec(0, 0, 0);
    check("R2 gated by ie", in_entry, 0);
    check("R2 ip held", ip_flag, 1);
    fetch_cycle(0);
    finish_exec(0, 1, 0);
    check("R8 old ie used", in_entry, 0);
    check("R8 ie set", ie_flag, 1);
    fetch_cycle(0);
    finish_exec(0, 0, 0);
    check("R8 nested entry", in_entry, 1);
    enter(4'h3, 0);
    do_return("R6 inner return");
    do_return("R6 outer return");

    fetch_cycle(0);
    finish_exec(0, 0, 1);
    check("R2 same-edge irq not taken", in_entry, 0);
    check("R7 ip set same edge", ip_flag, 1);
    fetch_cycle(0);
    finish_exec(0, 0, 0);
    check("R2 taken next boundary", in_entry, 1);
    enter(4'hC, 0);
    do_return("R6 return after late irq");

    do_reset();
    for (int k = 0; k < 9; k++) begin
      fetch_cycle(0);
      finish_exec(0, 1, 0);
      fetch_cycle(1);
      finish_exec(0, 0, 0);
      check("R9 nested entry", in_entry, 1);
      enter(4'(k), 0);
      check("R9 err flag", stack_err, (k == 8) ? 1 : 0);
    end
    msp = 8;
    for (int k = 0; k < 8; k++) begin
      do_return("R9 LIFO order");
    end
    check("R11 err kept", stack_err, 1);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule